// File: doc/BRIEF.md
# Three-Level Interrupt Priority Controller

This block collects interrupt requests from a non-maskable line, a break line and a set of peripheral sources. It picks one winner and offers it to the CPU as a vector number. Every source owns its own vector, so a handler never has to poll to find out who asked. Each peripheral source carries one priority bit. Two CPU mask flags, `flag_i` and `flag_ui`, and a two-bit control-mode field decide which classes of request are blocked. This gives three mask levels:

- nothing masked;
- only low-priority sources masked;
- every maskable request masked.

The non-maskable request is never blocked and always wins.

The CPU side is a valid/ready pair. `irq_valid` with `irq_vector` is the offer, and `irq_ready` is the acknowledge. Once an offer is up, it does not change until the CPU takes it, which is how the CPU applies back-pressure. Peripheral sources can be latched or level.

- A latched source is set by a single-cycle request pulse. It stays pending until its vector is accepted.
- A level source follows its request line.

The mode field and the two flags pass through one register stage before they take effect. That stage resets to simple mode with `flag_i` set.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst_n` is low, `irq_valid` is 0 and `irq_vector` is 0. All pending state is cleared.
- R2: A pending non-maskable request is offered ahead of every other request, whatever the mode and flags are.
- R3: In simple mode (mode code 2'b00), `flag_i`=1 blocks the break request and all peripheral sources. With `flag_i`=0, the priority bits are ignored and the order is: break first, then sources by lowest index.
- R4: In priority mode (mode code 2'b10) with `flag_i`=0, the break request comes first. High-priority sources (`src_hipri`=1) come next, then low-priority ones. Within a class, the lowest index wins.
- R5: In priority mode with `flag_i`=1 and `flag_ui`=0, low-priority sources are blocked. The break request and high-priority sources are still offered.
- R6: In priority mode with `flag_i`=1 and `flag_ui`=1, the break request and all peripheral sources are blocked.
- R7: The vector mapping is fixed: non-maskable is vector 0, break is vector 1, and source k is vector k+2.
- R8: While `irq_valid`=1 and `irq_ready`=0, `irq_valid` and `irq_vector` hold. Any new request, including a non-maskable one, waits. In the cycle after an acceptance (`irq_valid` and `irq_ready` both 1), `irq_valid` is 0.
- R9: The non-maskable line, the break line and sources with `src_latch`=1 are latched. A one-cycle request sets a pending flag, and only acceptance of that source's vector clears it. A request in the same cycle as the acceptance keeps the source pending.
- R10: A source with `src_latch`=0 is pending exactly while its request line is high. A request dropped before it is offered is lost. A line still high after acceptance is offered again.
- R11: A request or configuration change sampled at clock edge t shows up on `irq_valid` and `irq_vector` after edge t+1.
- R12: Mode codes 2'b01 and 2'b11 behave as simple mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request pulse |
| brk_req | input | 1 | Break request pulse |
| src_req | input | N_SRC | Peripheral request lines |
| src_latch | input | N_SRC | Per source: 1 = latched, 0 = level |
| src_hipri | input | N_SRC | Per source: 1 = high priority class |
| mode | input | 2 | Control mode, 2'b10 = priority mode, others = simple |
| flag_i | input | 1 | CPU mask flag I |
| flag_ui | input | 1 | CPU mask flag UI |
| irq_valid | output | 1 | An interrupt is offered to the CPU |
| irq_ready | input | 1 | CPU accepts the offered interrupt |
| irq_vector | output | clog2(N_SRC+2) | Vector number of the offer |

## Verification
The assertions assume that all inputs are two-state and change only away from the rising edge. They also assume that `irq_ready` carries meaning only while `irq_valid` is high.

The stimulus keeps to these rules by driving every input at the falling edge. It raises `irq_ready` at random, with or without an offer, since a stray ready without valid must be harmless.

Random phases also flip the mode, the flags, the priority bits and the latch choice while an offer is held. This shows that a held offer ignores those changes.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Fixed vector slots ahead of the peripheral sources
  localparam int unsigned VEC_NMI  = 0;
  localparam int unsigned VEC_BRK  = 1;
  localparam int unsigned VEC_SRC0 = 2;

  // Mode code that selects the priority mode; every other code is simple mode
  localparam logic [1:0] MODE_PRIO = 2'b10;

  typedef struct packed {
    logic prio_mode;
    logic i_flag;
    logic ui_flag;
  } irq_cfg_t;

  localparam irq_cfg_t CFG_RESET = '{prio_mode: 1'b0, i_flag: 1'b1, ui_flag: 1'b0};

endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import irq_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       flag_i,
  input  logic       flag_ui,
  output irq_cfg_t   cfg_q
);

  irq_cfg_t cfg_d;

  always_comb begin
    cfg_d.prio_mode = (mode == MODE_PRIO);
    cfg_d.i_flag    = flag_i;
    cfg_d.ui_flag   = flag_ui;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned N_TOT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TOT-1:0] req,
  input  logic [N_TOT-1:0] latch,
  input  logic [N_TOT-1:0] clr,
  output logic [N_TOT-1:0] pend
);

  for (genvar g = 0; g < N_TOT; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)          pend[g] <= 1'b0;
      else if (latch[g])   pend[g] <= req[g] | (pend[g] & ~clr[g]);
      else                 pend[g] <= req[g];
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter  int unsigned N_SRC = 8,
  localparam int unsigned N_TOT = N_SRC + 2,
  localparam int unsigned VEC_W = $clog2(N_TOT)
) (
  input  logic [N_TOT-1:0] pend,
  input  logic [N_SRC-1:0] hipri,
  input  irq_cfg_t         cfg,
  output logic             win_valid,
  output logic [VEC_W-1:0] win_vec
);

  logic             block_all;
  logic             block_low;
  logic [N_TOT-1:0] hi_req;
  logic [N_TOT-1:0] lo_req;

  assign block_all = cfg.i_flag & (~cfg.prio_mode | cfg.ui_flag);
  assign block_low = cfg.i_flag;

  // slot 0 is handled ahead of both classes
  assign hi_req[VEC_NMI] = 1'b0;
  assign lo_req[VEC_NMI] = 1'b0;
  // break ignores the priority bits but obeys the full mask
  assign hi_req[VEC_BRK] = pend[VEC_BRK] & ~block_all;
  assign lo_req[VEC_BRK] = 1'b0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic in_hi;
    assign in_hi                = ~cfg.prio_mode | hipri[g];
    assign hi_req[VEC_SRC0 + g] = pend[VEC_SRC0 + g] &  in_hi & ~block_all;
    assign lo_req[VEC_SRC0 + g] = pend[VEC_SRC0 + g] & ~in_hi & ~block_low;
  end

  function automatic logic [VEC_W-1:0] lowest_set(input logic [N_TOT-1:0] v);
    logic [VEC_W-1:0] idx;
    idx = '0;
    for (int k = N_TOT - 1; k >= 0; k--) begin
      if (v[k]) idx = VEC_W'(k);
    end
    return idx;
  endfunction

  always_comb begin
    win_valid = 1'b1;
    win_vec   = '0;
    if (pend[VEC_NMI])  win_vec = VEC_W'(VEC_NMI);
    else if (|hi_req)   win_vec = lowest_set(hi_req);
    else if (|lo_req)   win_vec = lowest_set(lo_req);
    else                win_valid = 1'b0;
  end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned N_TOT = 10,
  parameter int unsigned VEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  input  logic [VEC_W-1:0] win_vec,
  input  logic             ready,
  output logic             valid,
  output logic [VEC_W-1:0] vec,
  output logic [N_TOT-1:0] clr
);

  logic take;
  assign take = valid & ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      vec   <= '0;
    end else if (valid) begin
      if (ready) valid <= 1'b0;
    end else if (win_valid) begin
      valid <= 1'b1;
      vec   <= win_vec;
    end
  end

  for (genvar g = 0; g < N_TOT; g++) begin : g_clr
    assign clr[g] = take & (vec == VEC_W'(g));
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter  int unsigned N_SRC = 8,
  localparam int unsigned N_TOT = N_SRC + 2,
  localparam int unsigned VEC_W = $clog2(N_TOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_req,
  input  logic             brk_req,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_latch,
  input  logic [N_SRC-1:0] src_hipri,
  input  logic [1:0]       mode,
  input  logic             flag_i,
  input  logic             flag_ui,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vector
);

  irq_cfg_t         cfg_q;
  logic [N_TOT-1:0] req_all;
  logic [N_TOT-1:0] latch_all;
  logic [N_TOT-1:0] clr_all;
  logic [N_TOT-1:0] pend_q;
  logic             win_valid;
  logic [VEC_W-1:0] win_vec;

  assign req_all   = {src_req, brk_req, nmi_req};
  assign latch_all = {src_latch, 2'b11};

  irq_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .flag_i  (flag_i),
    .flag_ui (flag_ui),
    .cfg_q   (cfg_q)
  );

  irq_pending #(.N_TOT(N_TOT)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_all),
    .latch (latch_all),
    .clr   (clr_all),
    .pend  (pend_q)
  );

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend      (pend_q),
    .hipri     (src_hipri),
    .cfg       (cfg_q),
    .win_valid (win_valid),
    .win_vec   (win_vec)
  );

  irq_out_stage #(.N_TOT(N_TOT), .VEC_W(VEC_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid),
    .win_vec   (win_vec),
    .ready     (irq_ready),
    .valid     (irq_valid),
    .vec       (irq_vector),
    .clr       (clr_all)
  );

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter  int unsigned N_SRC = 8,
  localparam int unsigned N_TOT = N_SRC + 2,
  localparam int unsigned VEC_W = $clog2(N_TOT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic [VEC_W-1:0] irq_vector,
  input logic             nmi_pend,
  input irq_cfg_t         cfg_q
);

  logic full_block;
  logic simple_block;
  assign full_block   = cfg_q.prio_mode & cfg_q.i_flag & cfg_q.ui_flag;
  assign simple_block = ~cfg_q.prio_mode & cfg_q.i_flag;

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_vector)); // R8

  AST_GAP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ready |=> !irq_valid); // R8

  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ({1'b0, irq_vector} < (VEC_W + 1)'(N_TOT))); // R7

  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) && $past(nmi_pend) |-> irq_vector == VEC_W'(VEC_NMI)); // R2

  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) && $past(full_block) |-> irq_vector == VEC_W'(VEC_NMI)); // R6

  AST_SIMPLE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) && $past(simple_block) |-> irq_vector == VEC_W'(VEC_NMI)); // R3

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_valid  (irq_valid),
  .irq_ready  (irq_ready),
  .irq_vector (irq_vector),
  .nmi_pend   (pend_q[0]),
  .cfg_q      (cfg_q)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

  localparam int N  = 8;
  localparam int NT = N + 2;
  localparam int VW = $clog2(NT);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          nmi_req, brk_req;
  logic [N-1:0]  src_req, src_latch, src_hipri;
  logic [1:0]    mode;
  logic          flag_i, flag_ui;
  logic          irq_valid, irq_ready;
  logic [VW-1:0] irq_vector;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .brk_req(brk_req),
    .src_req(src_req), .src_latch(src_latch), .src_hipri(src_hipri),
    .mode(mode), .flag_i(flag_i), .flag_ui(flag_ui),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference choice from the requirements; -1 when nothing may be offered
  function automatic int ref_pick(input logic [NT-1:0] p, input logic [N-1:0] hp,
                                  input bit pm, input bit fi, input bit fu);
    bit all_off;
    all_off = fi && (!pm || fu);
    if (p[0]) return 0;
    if (!all_off) begin
      if (p[1]) return 1;
      for (int k = 0; k < N; k++) if (p[k+2] && (!pm || hp[k])) return k + 2;
    end
    if (pm && !fi) begin
      for (int k = 0; k < N; k++) if (p[k+2] && !hp[k]) return k + 2;
    end
    return -1;
  endfunction

  // Cycle model of the requirements (R9, R10, R11, R8)
  logic [NT-1:0] m_pend;
  bit            m_pm, m_i, m_ui, m_valid;
  logic [VW-1:0] m_vec;

  always @(posedge clk) begin
    int w;
    bit lt, rq, cl;
    if (!rst_n) begin
      m_pend <= '0; m_pm <= 1'b0; m_i <= 1'b1; m_ui <= 1'b0;
      m_valid <= 1'b0; m_vec <= '0;
    end else begin
      w = ref_pick(m_pend, src_hipri, m_pm, m_i, m_ui);
      for (int k = 0; k < NT; k++) begin
        lt = (k < 2) ? 1'b1 : src_latch[k-2];
        rq = (k == 0) ? nmi_req : (k == 1) ? brk_req : src_req[k-2];
        cl = m_valid && irq_ready && (int'(m_vec) == k);
        m_pend[k] <= lt ? (rq | (m_pend[k] & !cl)) : rq;
      end
      m_pm <= (mode == 2'b10); m_i <= flag_i; m_ui <= flag_ui;
      if (m_valid) begin
        if (irq_ready) m_valid <= 1'b0;
      end else if (w >= 0) begin
        m_valid <= 1'b1; m_vec <= VW'(w);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R11 valid vs model", int'(irq_valid), int'(m_valid));
      if (m_valid) check("R7 vector vs model", int'(irq_vector), int'(m_vec));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] md, input logic fi, input logic fu);
    mode = md; flag_i = fi; flag_ui = fu;
    tick(1);
  endtask

  task automatic pulse(input logic [NT-1:0] lines);
    nmi_req = lines[0]; brk_req = lines[1]; src_req = lines[NT-1:2];
    tick(1);
    nmi_req = 1'b0; brk_req = 1'b0; src_req = '0;
  endtask

  task automatic take();
    irq_ready = 1'b1; tick(1); irq_ready = 1'b0; tick(1);
  endtask

  task automatic expect_vec(input string req, input int v);
    check(req, int'(irq_valid), 1);
    check(req, int'(irq_vector), v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nmi_req = 0; brk_req = 0; src_req = '0;
    src_latch = '1; src_hipri = 8'b0101_0000;
    mode = 2'b00; flag_i = 1'b1; flag_ui = 1'b0; irq_ready = 1'b0;
    tick(4);
    check("R1 valid in reset", int'(irq_valid), 0);
    check("R1 vector in reset", int'(irq_vector), 0);
    rst_n = 1'b1;
    tick(2);

    // R3 simple mode: I blocks, then fixed order ignoring priority bits
    pulse(NT'(1) << 5); tick(2);
    check("R3 blocked by I", int'(irq_valid), 0);
    set_cfg(2'b00, 1'b0, 1'b0); tick(1);
    expect_vec("R3 src3 accepted", 5);
    pulse((NT'(1) << 3) | (NT'(1) << 8));
    take(); expect_vec("R3 lowest index wins", 3);
    take(); expect_vec("R3 next source", 8);
    take(); check("R9 pending cleared on take", int'(irq_valid), 0);

    // R4 priority mode: high class first, tie by index
    set_cfg(2'b10, 1'b0, 1'b0);
    pulse((NT'(1) << 4) | (NT'(1) << 8) | (NT'(1) << 6)); tick(1);
    expect_vec("R4 high class lowest index", 6);
    take(); expect_vec("R4 second high", 8);
    take(); expect_vec("R4 low after high", 4);
    take(); check("R4 empty", int'(irq_valid), 0);

    // R5 I=1 UI=0 in priority mode
    set_cfg(2'b10, 1'b1, 1'b0);
    pulse((NT'(1) << 3) | (NT'(1) << 8) | NT'(2)); tick(1);
    expect_vec("R5 break first", 1);
    take(); expect_vec("R5 high still open", 8);
    take(); check("R5 low blocked", int'(irq_valid), 0);
    set_cfg(2'b10, 1'b0, 1'b0); tick(1);
    expect_vec("R5 low after unmask", 3);
    take();

    // R6 full block, R2 NMI exempt
    set_cfg(2'b10, 1'b1, 1'b1);
    pulse(NT'(2) | (NT'(1) << 8)); tick(2);
    check("R6 all maskable blocked", int'(irq_valid), 0);
    pulse(NT'(1)); tick(1);
    expect_vec("R2 NMI under full block", 0);
    take(); check("R6 still blocked", int'(irq_valid), 0);
    set_cfg(2'b10, 1'b0, 1'b0); tick(1);
    expect_vec("R6 break after unmask", 1);
    take(); expect_vec("R6 source after unmask", 8);
    take();

    // R8 hold while NMI arrives
    pulse(NT'(1) << 7); tick(1);
    expect_vec("R8 offer up", 7);
    pulse(NT'(1)); tick(4);
    expect_vec("R8 held against NMI", 7);
    take(); expect_vec("R8 NMI after take", 0);
    take(); check("R8 idle", int'(irq_valid), 0);

    // R9 request in the same cycle as take; R11 latency
    pulse(NT'(1) << 2);
    check("R11 not yet visible", int'(irq_valid), 0);
    tick(1); expect_vec("R11 visible after second edge", 2);
    irq_ready = 1'b1; src_req[0] = 1'b1; tick(1);
    irq_ready = 1'b0; src_req[0] = 1'b0; tick(1);
    expect_vec("R9 re-pending on take", 2);
    take(); check("R9 cleared", int'(irq_valid), 0);

    // R10 level source
    src_latch[1] = 1'b0; src_req[1] = 1'b1; tick(2);
    expect_vec("R10 level offered", 3);
    take(); expect_vec("R10 still high re-offered", 3);
    src_req[1] = 1'b0; take();
    check("R10 dropped line gone", int'(irq_valid), 0);
    set_cfg(2'b00, 1'b1, 1'b0);
    src_req[1] = 1'b1; tick(2); src_req[1] = 1'b0;
    set_cfg(2'b00, 1'b0, 1'b0); tick(1);
    check("R10 withdrawn before offer", int'(irq_valid), 0);
    src_latch[1] = 1'b1;

    // R12 reserved codes act as simple mode
    set_cfg(2'b11, 1'b1, 1'b0);
    pulse((NT'(1) << 4) | (NT'(1) << 8)); tick(1);
    check("R12 code 11 blocks all", int'(irq_valid), 0);
    set_cfg(2'b01, 1'b0, 1'b0); tick(1);
    expect_vec("R12 code 01 ignores priority", 4);
    take(); expect_vec("R12 then next", 8);
    take();

    // Random phase checked against the model
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 6000; c++) begin
      if (c % 400 == 0) begin
        src_latch = N'($urandom); src_hipri = N'($urandom);
      end
      if (c % 37 == 0) begin
        mode = 2'($urandom); flag_i = 1'($urandom); flag_ui = 1'($urandom);
      end
      nmi_req = ($urandom % 90 == 0);
      brk_req = ($urandom % 40 == 0);
      for (int k = 0; k < N; k++) begin
        if (src_latch[k]) src_req[k] = ($urandom % 25 == 0);
        else if ($urandom % 15 == 0) src_req[k] = ~src_req[k];
      end
      irq_ready = ($urandom % 3 == 0);
      tick(1);
    end
    nmi_req = 0; brk_req = 0; src_req = '0; irq_ready = 1'b0;
    tick(4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule